// File: doc/BRIEF.md
# Addressable Boolean Flag Register File

This block stores sixteen one-bit boolean flags that conditional branches name directly by index, so a branch needs no separate test instruction in front of it. Compare instructions deposit their boolean result into any flag. A move operation copies one chosen bit of a general register into a flag. The ALU status results (zero, negative, positive, carry, overflow) sit in the same index space, so every condition is tested by one branch form.

The early decode stage presents a flag index and a sense bit. In the same cycle the block tells decode whether to treat the branch as an unconditional jump or as a no-op. A flag write in the current cycle is forwarded to that decision.

Top module: `boolFlagFile`

## Requirements
- R1: After reset every flag reads 0, so a branch with sense 0 on any index resolves to jump.
- R2: When the compare write port is enabled, the flag at its index takes its value, and it is seen by branches from the next cycle onward.
- R3: When the move port is enabled, the flag at its index takes bit `movBitSel` of `movSrcReg` (bit 0 is the least significant bit).
- R4: Indices 0 to 4 hold zero, negative, positive, carry and overflow, taken from `aluFlagsIn` bits 0 to 4 respectively. They are loaded only in cycles where `aluSetFlags` is 1, and otherwise they keep their value.
- R5: Index 5 always reads 0. Writes to it from any port are ignored.
- R6: When `brValid` is 1, exactly one of `brJump` and `brNop` is 1: `brJump` when the selected flag equals `brSense`, and `brNop` otherwise. When `brValid` is 0, both outputs are 0.
- R7: A write to the flag a branch reads in the same cycle is forwarded, so the branch resolves on the newly written value.
- R8: When several sources write the same flag in one cycle, the ALU update wins over the move port, and the move port wins over the compare port.
- R9: A flag that no port writes in a cycle keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cmpWrEn | input | 1 | Compare result write enable |
| cmpWrIdx | input | 4 | Compare destination flag index |
| cmpWrVal | input | 1 | Compare boolean result |
| movWrEn | input | 1 | Move-bit write enable |
| movWrIdx | input | 4 | Move destination flag index |
| movSrcReg | input | 32 | General register supplying the bit |
| movBitSel | input | 5 | Bit position in movSrcReg |
| aluSetFlags | input | 1 | Set-flags enable of the current ALU instruction |
| aluFlagsIn | input | 5 | ALU status: bit 0 zero, 1 negative, 2 positive, 3 carry, 4 overflow |
| brValid | input | 1 | A flag-testing branch is in early decode |
| brIdx | input | 4 | Flag index named by the branch |
| brSense | input | 1 | Flag value for which the branch is taken |
| brJump | output | 1 | Branch resolves to an unconditional jump |
| brNop | output | 1 | Branch resolves to a no-op |

## Verification
The hardest case to reach is a branch that reads a flag while two or three sources write that same flag in the same cycle, because both forwarding and write priority decide the result at once. Random stimulus draws all indices from a small pool that centres on the ALU range and the constant-zero slot, so such collisions happen often. Directed cycles then line up all three writers on one ALU index and on the constant-zero index.

// File: rtl/bff_pkg.sv
package bff_pkg;
  localparam int FLAG_CNT = 16;
  localparam int IDX_W    = $clog2(FLAG_CNT);
  localparam int ALU_CNT  = 5;
  localparam int ZERO_IDX = 5;

  typedef struct packed {
    logic [FLAG_CNT-1:0] cmpSel;
    logic [FLAG_CNT-1:0] movSel;
    logic [FLAG_CNT-1:0] aluSel;
    logic                cmpVal;
    logic                movVal;
  } wrStrobe_t;
endpackage

// File: rtl/flagCtrl.sv
module flagCtrl
  import bff_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SEL_W = $clog2(DATA_W)
) (
  input  logic             cmpWrEn,
  input  logic [IDX_W-1:0] cmpWrIdx,
  input  logic             cmpWrVal,
  input  logic             movWrEn,
  input  logic [IDX_W-1:0] movWrIdx,
  input  logic [DATA_W-1:0] movSrcReg,
  input  logic [SEL_W-1:0] movBitSel,
  input  logic             aluSetFlags,
  output wrStrobe_t        strobes
);
  // Per-index decode of the three write sources; constant slot never selected.
  for (genvar i = 0; i < FLAG_CNT; i++) begin : gDec
    if (i == ZERO_IDX) begin : gConst
      assign strobes.cmpSel[i] = 1'b0;
      assign strobes.movSel[i] = 1'b0;
      assign strobes.aluSel[i] = 1'b0;
    end else if (i < ALU_CNT) begin : gAlu
      assign strobes.cmpSel[i] = cmpWrEn && (cmpWrIdx == IDX_W'(i));
      assign strobes.movSel[i] = movWrEn && (movWrIdx == IDX_W'(i));
      assign strobes.aluSel[i] = aluSetFlags;
    end else begin : gGen
      assign strobes.cmpSel[i] = cmpWrEn && (cmpWrIdx == IDX_W'(i));
      assign strobes.movSel[i] = movWrEn && (movWrIdx == IDX_W'(i));
      assign strobes.aluSel[i] = 1'b0;
    end
  end

  assign strobes.cmpVal = cmpWrVal;
  assign strobes.movVal = movSrcReg[movBitSel];
endmodule

// File: rtl/flagStore.sv
module flagStore
  import bff_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  wrStrobe_t          strobes,
  input  logic [ALU_CNT-1:0] aluFlagsIn,
  input  logic               brValid,
  input  logic [IDX_W-1:0]   brIdx,
  input  logic               brSense,
  output logic               brJump,
  output logic               brNop
);
  logic [FLAG_CNT-1:0] nextFlags;

  for (genvar i = 0; i < FLAG_CNT; i++) begin : gBit
    if (i == ZERO_IDX) begin : gConst
      assign nextFlags[i] = 1'b0;
    end else begin : gReg
      logic curBit;
      logic aluBit;
      if (i < ALU_CNT) begin : gAluSrc
        assign aluBit = aluFlagsIn[i];
      end else begin : gNoAlu
        assign aluBit = 1'b0;
      end
      // Priority: ALU update, then move, then compare, else hold.
      always_comb begin
        if (strobes.aluSel[i])      nextFlags[i] = aluBit;
        else if (strobes.movSel[i]) nextFlags[i] = strobes.movVal;
        else if (strobes.cmpSel[i]) nextFlags[i] = strobes.cmpVal;
        else                        nextFlags[i] = curBit;
      end
      always_ff @(posedge clk) begin
        if (!rstN) curBit <= 1'b0;
        else       curBit <= nextFlags[i];
      end
    end
  end

  // Early-decode read sees this cycle's writes (forwarding through nextFlags).
  logic rdBit;
  assign rdBit  = nextFlags[brIdx];
  assign brJump = brValid && (rdBit == brSense);
  assign brNop  = brValid && (rdBit != brSense);
endmodule

// File: rtl/boolFlagFile.sv
module boolFlagFile
  import bff_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SEL_W = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmpWrEn,
  input  logic [IDX_W-1:0]   cmpWrIdx,
  input  logic               cmpWrVal,
  input  logic               movWrEn,
  input  logic [IDX_W-1:0]   movWrIdx,
  input  logic [DATA_W-1:0]  movSrcReg,
  input  logic [SEL_W-1:0]   movBitSel,
  input  logic               aluSetFlags,
  input  logic [ALU_CNT-1:0] aluFlagsIn,
  input  logic               brValid,
  input  logic [IDX_W-1:0]   brIdx,
  input  logic               brSense,
  output logic               brJump,
  output logic               brNop
);
  wrStrobe_t strobes;

  flagCtrl #(.DATA_W(DATA_W)) uCtrl (
    .cmpWrEn    (cmpWrEn),
    .cmpWrIdx   (cmpWrIdx),
    .cmpWrVal   (cmpWrVal),
    .movWrEn    (movWrEn),
    .movWrIdx   (movWrIdx),
    .movSrcReg  (movSrcReg),
    .movBitSel  (movBitSel),
    .aluSetFlags(aluSetFlags),
    .strobes    (strobes)
  );

  flagStore uStore (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .aluFlagsIn(aluFlagsIn),
    .brValid   (brValid),
    .brIdx     (brIdx),
    .brSense   (brSense),
    .brJump    (brJump),
    .brNop     (brNop)
  );
endmodule

// File: rtl/flagFileChk.sv
module flagFileChk
  import bff_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SEL_W = $clog2(DATA_W)
) (
  input logic               clk,
  input logic               rstN,
  input logic               cmpWrEn,
  input logic [IDX_W-1:0]   cmpWrIdx,
  input logic               cmpWrVal,
  input logic               movWrEn,
  input logic [IDX_W-1:0]   movWrIdx,
  input logic [DATA_W-1:0]  movSrcReg,
  input logic [SEL_W-1:0]   movBitSel,
  input logic               aluSetFlags,
  input logic [ALU_CNT-1:0] aluFlagsIn,
  input logic               brValid,
  input logic [IDX_W-1:0]   brIdx,
  input logic               brSense,
  input logic               brJump,
  input logic               brNop
);
  logic brOnAlu;
  assign brOnAlu = (int'(brIdx) < ALU_CNT);

  AST_RESOLVE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({brJump, brNop})) else $error("resolve outputs both high"); // R6

  AST_RESOLVE_VALID: assert property (@(posedge clk) disable iff (!rstN)
    brValid == (brJump || brNop)) else $error("resolve does not track valid"); // R6

  AST_ZERO_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    (brValid && brIdx == IDX_W'(ZERO_IDX)) |-> (brJump == !brSense))
    else $error("constant slot not zero"); // R5

  AST_ALU_FWD: assert property (@(posedge clk) disable iff (!rstN)
    (brValid && aluSetFlags && brOnAlu) |-> (brJump == (aluFlagsIn[brIdx] == brSense)))
    else $error("ALU write not forwarded"); // R8

  AST_MOV_FWD: assert property (@(posedge clk) disable iff (!rstN)
    (brValid && movWrEn && brIdx == movWrIdx && brIdx != IDX_W'(ZERO_IDX)
     && !(aluSetFlags && brOnAlu))
    |-> (brJump == (movSrcReg[movBitSel] == brSense)))
    else $error("move write not forwarded"); // R3

  AST_CMP_FWD: assert property (@(posedge clk) disable iff (!rstN)
    (brValid && cmpWrEn && brIdx == cmpWrIdx && brIdx != IDX_W'(ZERO_IDX)
     && !(aluSetFlags && brOnAlu) && !(movWrEn && movWrIdx == cmpWrIdx))
    |-> (brJump == (cmpWrVal == brSense)))
    else $error("compare write not forwarded"); // R7
endmodule

bind boolFlagFile flagFileChk #(.DATA_W(DATA_W)) uChk (.*);

// File: tb/sim_boolFlagFile.sv
`timescale 1ns/1ps
module sim_boolFlagFile;
  logic        clk = 1'b0;
  logic        rstN;
  logic        cmpWrEn, cmpWrVal, movWrEn, aluSetFlags, brValid, brSense;
  logic [3:0]  cmpWrIdx, movWrIdx, brIdx;
  logic [31:0] movSrcReg;
  logic [4:0]  movBitSel, aluFlagsIn;
  logic        brJump, brNop;

  int total = 0;
  int bad   = 0;
  bit finished = 0;
  logic [15:0] mdl;

  always #5 clk = ~clk;

  boolFlagFile u0 (.*);

  function automatic logic [15:0] calcNext(logic [15:0] cur);
    logic [15:0] n = cur;
    if (cmpWrEn) n[cmpWrIdx] = cmpWrVal;
    if (movWrEn) n[movWrIdx] = movSrcReg[movBitSel];
    if (aluSetFlags) n[4:0] = aluFlagsIn;
    n[5] = 1'b0;
    return n;
  endfunction

  task automatic idleIn();
    cmpWrEn = 0; cmpWrIdx = 0; cmpWrVal = 0;
    movWrEn = 0; movWrIdx = 0; movSrcReg = 0; movBitSel = 0;
    aluSetFlags = 0; aluFlagsIn = 0;
    brValid = 0; brIdx = 0; brSense = 0;
  endtask

  // Inputs set after negedge; call checks 2 ns later; model commits at posedge.
  task automatic checkRes(string req);
    logic [15:0] n = calcNext(mdl);
    logic expJ = brValid && (n[brIdx] == brSense);
    logic expN = brValid && (n[brIdx] != brSense);
    #2;
    total++;
    if (brJump !== expJ || brNop !== expN) begin
      bad++;
      $display("FAIL %s idx=%0d jump/nop actual=%b%b expected=%b%b",
               req, brIdx, brJump, brNop, expJ, expN);
    end
    @(posedge clk);
    mdl = n;
    @(negedge clk);
  endtask

  function automatic string tagFor();
    if (!brValid) return "R6";
    if (brIdx == 4'd5) return "R5";
    if (aluSetFlags && brIdx < 5 && (movWrEn && movWrIdx == brIdx || cmpWrEn && cmpWrIdx == brIdx)) return "R8";
    if (movWrEn && cmpWrEn && movWrIdx == brIdx && cmpWrIdx == brIdx) return "R8";
    if (cmpWrEn && cmpWrIdx == brIdx) return "R7";
    if (movWrEn && movWrIdx == brIdx) return "R3";
    if (aluSetFlags && brIdx < 5) return "R4";
    return "R9";
  endfunction

  function automatic logic [3:0] pickIdx();
    int r = $urandom_range(0, 9);
    if (r < 6) return 4'($urandom_range(0, 7));
    return 4'($urandom_range(0, 15));
  endfunction

  initial begin
    #2_000_000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idleIn();
    rstN = 0;
    mdl = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;

    // R1: all flags zero after reset, sense 0 taken everywhere
    for (int i = 0; i < 16; i++) begin
      brValid = 1; brIdx = 4'(i); brSense = 0;
      checkRes("R1");
    end
    // R6: no valid -> both low
    idleIn(); checkRes("R6");

    // R2: compare write, seen next cycle
    idleIn(); cmpWrEn = 1; cmpWrIdx = 4'd9; cmpWrVal = 1; checkRes("R2");
    idleIn(); brValid = 1; brIdx = 4'd9; brSense = 1; checkRes("R2");

    // R3: move top bit
    idleIn(); movWrEn = 1; movWrIdx = 4'd12; movSrcReg = 32'h8000_0000; movBitSel = 5'd31;
    brValid = 1; brIdx = 4'd12; brSense = 1; checkRes("R3");
    idleIn(); movWrEn = 1; movWrIdx = 4'd12; movSrcReg = 32'hFFFF_FFFE; movBitSel = 5'd0;
    brValid = 1; brIdx = 4'd12; brSense = 0; checkRes("R3");

    // R4: ALU flags without enable do not load
    idleIn(); aluFlagsIn = 5'b11111; brValid = 1; brIdx = 4'd3; brSense = 0; checkRes("R4");
    idleIn(); aluSetFlags = 1; aluFlagsIn = 5'b01010; brValid = 1; brIdx = 4'd1; brSense = 1; checkRes("R4");
    idleIn(); aluFlagsIn = 5'b10101; brValid = 1; brIdx = 4'd1; brSense = 1; checkRes("R4");

    // R5: writes to constant slot ignored
    idleIn(); cmpWrEn = 1; cmpWrIdx = 4'd5; cmpWrVal = 1;
    movWrEn = 1; movWrIdx = 4'd5; movSrcReg = '1; brValid = 1; brIdx = 4'd5; brSense = 1; checkRes("R5");
    idleIn(); brValid = 1; brIdx = 4'd5; brSense = 0; checkRes("R5");

    // R8: three writers on one ALU index, then move vs compare on general index
    idleIn(); aluSetFlags = 1; aluFlagsIn = 5'b00000;
    cmpWrEn = 1; cmpWrIdx = 4'd2; cmpWrVal = 1;
    movWrEn = 1; movWrIdx = 4'd2; movSrcReg = '1;
    brValid = 1; brIdx = 4'd2; brSense = 0; checkRes("R8");
    idleIn(); cmpWrEn = 1; cmpWrIdx = 4'd7; cmpWrVal = 0;
    movWrEn = 1; movWrIdx = 4'd7; movSrcReg = 32'h1; movBitSel = 0;
    brValid = 1; brIdx = 4'd7; brSense = 1; checkRes("R8");

    // R7: forwarding of compare write
    idleIn(); cmpWrEn = 1; cmpWrIdx = 4'd14; cmpWrVal = 1;
    brValid = 1; brIdx = 4'd14; brSense = 1; checkRes("R7");

    // Random mix (tags R2..R9)
    for (int k = 0; k < 4000; k++) begin
      cmpWrEn     = 1'($urandom_range(0, 1));
      cmpWrIdx    = pickIdx();
      cmpWrVal    = 1'($urandom_range(0, 1));
      movWrEn     = 1'($urandom_range(0, 2) == 0);
      movWrIdx    = pickIdx();
      movSrcReg   = $urandom();
      movBitSel   = 5'($urandom_range(0, 31));
      aluSetFlags = 1'($urandom_range(0, 3) == 0);
      aluFlagsIn  = 5'($urandom_range(0, 31));
      brValid     = 1'($urandom_range(0, 7) != 0);
      brIdx       = pickIdx();
      brSense     = 1'($urandom_range(0, 1));
      checkRes(tagFor());
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule